// File: doc/BRIEF.md
# Vector Element Loop Controller

This block sequences the element loop of a vectorised instruction. Each time an instruction completes, the surrounding pipeline pulses a completion strobe. It also presents the current source and destination element steps, the vector length and a few mode flags. The controller answers one cycle later with the updated steps, a flag that allows the program counter to advance, a loop-reset pulse, a request to clear the vertical-first mode bit, and an end-test bit for the condition field.

The block has two sequencing styles. In horizontal-first operation the controller re-issues the same instruction by holding the program counter while both steps count up, and it releases the counter once an end is reached. In vertical-first operation the program counter always advances. The steps move only when the instruction in flight has raised an explicit step request. That request also reports whether the loop ended, so software can branch on it. Element execution and predicate-driven skipping belong to other blocks.

Top module: `vec_elem_loop_ctrl`

## Requirements
- R1: Horizontal case (vector length nonzero, no explicit request, vertical-first bit low). When the operation is vector and neither step equals length-1, both steps become input+1 and `pc_adv_o` is 0.
- R2: With `twin_pred_i`=1, the operation counts as vector when `out_vec_i` or `in_vec_i` is 1. With `twin_pred_i`=0, only `out_vec_i`=1 makes it vector.
- R3: Horizontal case with a scalar operation, or with either step equal to length-1: both steps become 0, and `loop_rst_o` and `pc_adv_o` are 1.
- R4: With the vertical-first bit set and no explicit request, `pc_adv_o` is 1, the steps equal the input steps, and `loop_rst_o` is 0.
- R5: An explicit step with neither step at length-1 gives steps of input+1, `pc_adv_o`=1, and `loop_rst_o`=0 and `vf_clr_o`=0. This holds whatever the vertical-first bit is.
- R6: An explicit step with either step at length-1 gives steps of 0, and `loop_rst_o`, `vf_clr_o` and `pc_adv_o` all 1.
- R7: On an explicit step, `cr_we_o` equals `rec_en_i`, and `end_test_o` is 0 when an end was reached and 1 otherwise. No other case ever raises `cr_we_o`.
- R8: A step request raised in any cycle of an instruction, including the completion cycle, applies at that instruction's completion. Every completion clears it, so the next instruction starts without a request.
- R9: A vector length of 0 gives `pc_adv_o`=1 and steps equal to the inputs, with `loop_rst_o`, `vf_clr_o` and `cr_we_o` all 0. This holds even when a request is pending.
- R10: Results appear on the cycle after the completion strobe. In cycles without a strobe, the pulse outputs are 0 and the step outputs hold.
- R11: While reset is high, all outputs and the pending request are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| done_i | input | 1 | instruction completion strobe |
| src_step_i | input | STEP_W | current source element step |
| dst_step_i | input | STEP_W | current destination element step |
| vlen_i | input | STEP_W | vector length |
| out_vec_i | input | 1 | output operand is a vector |
| in_vec_i | input | 1 | an input operand is a vector |
| twin_pred_i | input | 1 | twin-predicate operation |
| vf_mode_i | input | 1 | vertical-first mode bit |
| step_req_i | input | 1 | explicit step request from the current instruction |
| rec_en_i | input | 1 | record-result enable |
| src_step_o | output | STEP_W | updated source step |
| dst_step_o | output | STEP_W | updated destination step |
| pc_adv_o | output | 1 | program counter may advance |
| loop_rst_o | output | 1 | element loop reset pulse |
| vf_clr_o | output | 1 | clear the vertical-first mode bit |
| cr_we_o | output | 1 | write end-test into the condition field |
| end_test_o | output | 1 | end-test value (0 = end reached) |

## Verification
Two functions can land on the same completion edge: the explicit step request and the completion strobe. The same edge can also see the vertical-first bit alongside a request. A request is therefore raised both in the strobe cycle itself and several cycles before it. The vertical-first bit is held high while a request is present, and the bench confirms that the explicit-step result wins (R5, R6, R8). A request pending at a zero-length instruction must lose to the skip. The completion right after a consumed request must fall back to the plain vertical-first path, with unchanged steps and no condition write.

// File: rtl/vloop_pkg.sv
package vloop_pkg;
  typedef enum logic [1:0] {
    ACT_SKIP = 2'd0,
    ACT_EXPL = 2'd1,
    ACT_VERT = 2'd2,
    ACT_HORZ = 2'd3
  } vloop_act_e;

  localparam int NUM_LANES = 2;
  localparam int LANE_SRC  = 0;
  localparam int LANE_DST  = 1;
endpackage

// File: rtl/vloop_req_latch.sv
module vloop_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic done_i,
  input  logic req_i,
  output logic req_o
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst)         pend_q <= 1'b0;
    else if (done_i) pend_q <= 1'b0;
    else if (req_i)  pend_q <= 1'b1;
  end

  assign req_o = pend_q | req_i;
endmodule

// File: rtl/vloop_step_lane.sv
module vloop_step_lane #(
  parameter int STEP_W = 7
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [STEP_W-1:0] vlen_i,
  output logic              at_end_o,
  output logic [STEP_W-1:0] inc_o
);
  localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

  assign at_end_o = (vlen_i != '0) && (step_i == (vlen_i - ONE));
  assign inc_o    = step_i + ONE;
endmodule

// File: rtl/vloop_decide.sv
module vloop_decide
  import vloop_pkg::*;
(
  input  logic       vl_zero_i,
  input  logic       req_i,
  input  logic       vf_mode_i,
  input  logic       out_vec_i,
  input  logic       in_vec_i,
  input  logic       twin_pred_i,
  output vloop_act_e act_o,
  output logic       is_vec_o
);
  always_comb begin
    is_vec_o = twin_pred_i ? (out_vec_i | in_vec_i) : out_vec_i;
    if (vl_zero_i)      act_o = ACT_SKIP;
    else if (req_i)     act_o = ACT_EXPL;
    else if (vf_mode_i) act_o = ACT_VERT;
    else                act_o = ACT_HORZ;
  end
endmodule

// File: rtl/vec_elem_loop_ctrl.sv
module vec_elem_loop_ctrl
  import vloop_pkg::*;
#(
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [STEP_W-1:0] src_step_i,
  input  logic [STEP_W-1:0] dst_step_i,
  input  logic [STEP_W-1:0] vlen_i,
  input  logic              out_vec_i,
  input  logic              in_vec_i,
  input  logic              twin_pred_i,
  input  logic              vf_mode_i,
  input  logic              step_req_i,
  input  logic              rec_en_i,
  output logic [STEP_W-1:0] src_step_o,
  output logic [STEP_W-1:0] dst_step_o,
  output logic              pc_adv_o,
  output logic              loop_rst_o,
  output logic              vf_clr_o,
  output logic              cr_we_o,
  output logic              end_test_o
);
  logic [NUM_LANES-1:0][STEP_W-1:0] cur_step;
  logic [NUM_LANES-1:0][STEP_W-1:0] inc_step;
  logic [NUM_LANES-1:0][STEP_W-1:0] nxt_step;
  logic [NUM_LANES-1:0]             lane_end;
  logic       req_eff;
  logic       is_vec;
  logic       any_end;
  vloop_act_e act;

  logic nxt_pc_adv, nxt_loop_rst, nxt_vf_clr, nxt_cr_we, nxt_end_test;

  assign cur_step[LANE_SRC] = src_step_i;
  assign cur_step[LANE_DST] = dst_step_i;

  vloop_req_latch u_req (
    .clk    (clk),
    .rst    (rst),
    .done_i (done_i),
    .req_i  (step_req_i),
    .req_o  (req_eff)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    vloop_step_lane #(.STEP_W(STEP_W)) u_lane (
      .step_i   (cur_step[g]),
      .vlen_i   (vlen_i),
      .at_end_o (lane_end[g]),
      .inc_o    (inc_step[g])
    );
  end

  assign any_end = |lane_end;

  vloop_decide u_dec (
    .vl_zero_i   (vlen_i == '0),
    .req_i       (req_eff),
    .vf_mode_i   (vf_mode_i),
    .out_vec_i   (out_vec_i),
    .in_vec_i    (in_vec_i),
    .twin_pred_i (twin_pred_i),
    .act_o       (act),
    .is_vec_o    (is_vec)
  );

  always_comb begin
    nxt_step     = cur_step;
    nxt_pc_adv   = 1'b1;
    nxt_loop_rst = 1'b0;
    nxt_vf_clr   = 1'b0;
    nxt_cr_we    = 1'b0;
    nxt_end_test = 1'b0;
    unique case (act)
      ACT_SKIP, ACT_VERT: ;
      ACT_EXPL: begin
        nxt_cr_we    = rec_en_i;
        nxt_end_test = ~any_end;
        if (any_end) begin
          nxt_step     = '0;
          nxt_loop_rst = 1'b1;
          nxt_vf_clr   = 1'b1;
        end else begin
          nxt_step = inc_step;
        end
      end
      ACT_HORZ: begin
        if (is_vec && !any_end) begin
          nxt_step   = inc_step;
          nxt_pc_adv = 1'b0;
        end else begin
          nxt_step     = '0;
          nxt_loop_rst = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_step_o <= '0;
      dst_step_o <= '0;
      pc_adv_o   <= 1'b0;
      loop_rst_o <= 1'b0;
      vf_clr_o   <= 1'b0;
      cr_we_o    <= 1'b0;
      end_test_o <= 1'b0;
    end else begin
      pc_adv_o   <= done_i & nxt_pc_adv;
      loop_rst_o <= done_i & nxt_loop_rst;
      vf_clr_o   <= done_i & nxt_vf_clr;
      cr_we_o    <= done_i & nxt_cr_we;
      end_test_o <= done_i & nxt_end_test;
      if (done_i) begin
        src_step_o <= nxt_step[LANE_SRC];
        dst_step_o <= nxt_step[LANE_DST];
      end
    end
  end
endmodule

// File: rtl/vec_elem_loop_ctrl_chk.sv
module vec_elem_loop_ctrl_chk #(
  parameter int STEP_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              done_i,
  input logic [STEP_W-1:0] src_step_i,
  input logic [STEP_W-1:0] dst_step_i,
  input logic [STEP_W-1:0] vlen_i,
  input logic              vf_mode_i,
  input logic              step_req_i,
  input logic [STEP_W-1:0] src_step_o,
  input logic [STEP_W-1:0] dst_step_o,
  input logic              pc_adv_o,
  input logic              loop_rst_o,
  input logic              vf_clr_o,
  input logic              cr_we_o
);
  logic pend_seen;
  always_ff @(posedge clk) begin
    if (rst)         pend_seen <= 1'b0;
    else if (done_i) pend_seen <= 1'b0;
    else if (step_req_i) pend_seen <= 1'b1;
  end

  assert_reset_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    loop_rst_o |-> (src_step_o == '0 && dst_step_o == '0 && pc_adv_o));

  assert_vert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (done_i && vlen_i != '0 && vf_mode_i && !step_req_i && !pend_seen)
    |=> (pc_adv_o && !loop_rst_o && !cr_we_o
         && src_step_o == $past(src_step_i) && dst_step_o == $past(dst_step_i)));

  assert_vfclr_implies_reset_R6: assert property (@(posedge clk) disable iff (rst)
    vf_clr_o |-> loop_rst_o);

  assert_crwe_with_adv_R7: assert property (@(posedge clk) disable iff (rst)
    cr_we_o |-> pc_adv_o);

  assert_zero_len_skip_R9: assert property (@(posedge clk) disable iff (rst)
    (done_i && vlen_i == '0)
    |=> (pc_adv_o && !loop_rst_o && !vf_clr_o && !cr_we_o
         && src_step_o == $past(src_step_i)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !done_i |=> (!pc_adv_o && !loop_rst_o && !vf_clr_o && !cr_we_o
                 && $stable(src_step_o) && $stable(dst_step_o)));
endmodule

bind vec_elem_loop_ctrl vec_elem_loop_ctrl_chk #(.STEP_W(STEP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .done_i     (done_i),
  .src_step_i (src_step_i),
  .dst_step_i (dst_step_i),
  .vlen_i     (vlen_i),
  .vf_mode_i  (vf_mode_i),
  .step_req_i (step_req_i),
  .src_step_o (src_step_o),
  .dst_step_o (dst_step_o),
  .pc_adv_o   (pc_adv_o),
  .loop_rst_o (loop_rst_o),
  .vf_clr_o   (vf_clr_o),
  .cr_we_o    (cr_we_o)
);

// File: tb/vec_elem_loop_ctrl_bench.sv
module vec_elem_loop_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done_i = 1'b0;
  logic [W-1:0] src_step_i = '0, dst_step_i = '0, vlen_i = '0;
  logic out_vec_i = 0, in_vec_i = 0, twin_pred_i = 0, vf_mode_i = 0;
  logic step_req_i = 0, rec_en_i = 0;
  logic [W-1:0] src_step_o, dst_step_o;
  logic pc_adv_o, loop_rst_o, vf_clr_o, cr_we_o, end_test_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_elem_loop_ctrl #(.STEP_W(W)) u_vec_elem_loop_ctrl (
    .clk(clk), .rst(rst), .done_i(done_i),
    .src_step_i(src_step_i), .dst_step_i(dst_step_i), .vlen_i(vlen_i),
    .out_vec_i(out_vec_i), .in_vec_i(in_vec_i), .twin_pred_i(twin_pred_i),
    .vf_mode_i(vf_mode_i), .step_req_i(step_req_i), .rec_en_i(rec_en_i),
    .src_step_o(src_step_o), .dst_step_o(dst_step_o), .pc_adv_o(pc_adv_o),
    .loop_rst_o(loop_rst_o), .vf_clr_o(vf_clr_o), .cr_we_o(cr_we_o),
    .end_test_o(end_test_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int s, input int d, input int pc,
                         input int lr, input int vc, input int we, input int et);
    chk(tag, "src_step", src_step_o, s);
    chk(tag, "dst_step", dst_step_o, d);
    chk(tag, "pc_adv", pc_adv_o, pc);
    chk(tag, "loop_rst", loop_rst_o, lr);
    chk(tag, "vf_clr", vf_clr_o, vc);
    chk(tag, "cr_we", cr_we_o, we);
    chk(tag, "end_test", end_test_o, et);
  endtask

  // one completion strobe; results sampled on the following negedge
  task automatic instr(input int s, input int d, input int vl, input bit ov, input bit iv,
                       input bit tw, input bit vf, input bit rq, input bit re);
    @(negedge clk);
    src_step_i = W'(s); dst_step_i = W'(d); vlen_i = W'(vl);
    out_vec_i = ov; in_vec_i = iv; twin_pred_i = tw; vf_mode_i = vf;
    step_req_i = rq; rec_en_i = re; done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0; step_req_i = 1'b0;
  endtask

  task automatic t_reset();
    chk_all("R11", 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_horizontal();
    instr(1, 1, 4, 1, 0, 0, 0, 0, 0);
    chk_all("R1", 2, 2, 0, 0, 0, 0, 0);
    instr(3, 3, 4, 1, 0, 0, 0, 0, 0);
    chk_all("R3", 0, 0, 1, 1, 0, 0, 0);
    instr(1, 3, 4, 1, 0, 0, 0, 0, 0);
    chk_all("R3", 0, 0, 1, 1, 0, 0, 0);
  endtask

  task automatic t_classify();
    instr(0, 0, 5, 0, 1, 1, 0, 0, 0);
    chk_all("R2", 1, 1, 0, 0, 0, 0, 0);
    instr(0, 0, 5, 0, 1, 0, 0, 0, 0);
    chk_all("R2", 0, 0, 1, 1, 0, 0, 0);
  endtask

  task automatic t_vertical();
    instr(2, 2, 5, 1, 0, 0, 1, 0, 1);
    chk_all("R4", 2, 2, 1, 0, 0, 0, 0);
  endtask

  task automatic t_explicit();
    instr(0, 0, 3, 1, 0, 0, 1, 1, 1);
    chk_all("R5", 1, 1, 1, 0, 0, 1, 1);
    instr(2, 1, 3, 1, 0, 0, 1, 1, 1);
    chk_all("R6", 0, 0, 1, 1, 1, 1, 0);
    instr(0, 0, 3, 1, 0, 0, 1, 1, 0);
    chk("R7", "cr_we no record", cr_we_o, 0);
    chk("R7", "src_step", src_step_o, 1);
    instr(1, 1, 3, 1, 0, 0, 0, 1, 1);
    chk_all("R5", 2, 2, 1, 0, 0, 1, 1);
  endtask

  task automatic t_latch();
    @(negedge clk); step_req_i = 1'b1;
    @(negedge clk); step_req_i = 1'b0;
    repeat (3) @(negedge clk);
    instr(1, 1, 4, 1, 0, 0, 1, 0, 1);
    chk_all("R8", 2, 2, 1, 0, 0, 1, 1);
    instr(1, 1, 4, 1, 0, 0, 1, 0, 1);
    chk_all("R8", 1, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_zero_len();
    instr(5, 6, 0, 1, 1, 1, 1, 1, 1);
    chk_all("R9", 5, 6, 1, 0, 0, 0, 0);
    instr(2, 2, 0, 1, 0, 0, 0, 0, 0);
    chk_all("R9", 2, 2, 1, 0, 0, 0, 0);
  endtask

  task automatic t_idle();
    instr(0, 0, 6, 1, 0, 0, 0, 0, 0);
    chk("R10", "src after strobe", src_step_o, 1);
    repeat (3) @(negedge clk);
    chk_all("R10", 1, 1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_horizontal();
    t_classify();
    t_vertical();
    t_explicit();
    t_latch();
    t_zero_len();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule